// File: doc/BRIEF.md
# Sliced-integer FP16 multiply-accumulate unit

The unit sums a stream of half-precision products a·b into a running total. It has no floating-point multiplier. Each operand's 11-bit significand, hidden bit included, is cut into slices of 4, 4 and 3 bits. The nine slice pairs are multiplied one per cycle on a small integer multiplier and shifted into a partial-product register. The two biased exponents are added on their own path.

The finished product is placed against a 26-bit signed fixed-point accumulator. This placement uses a shifter that reaches only 8 positions either side of a reference exponent, and the first product after a clear sets that reference. A product outside the window is handled in one of two ways. One that is too small is dropped and recorded on a sticky flag. One that is too large saturates the sum and raises an overflow flag.

The result port always shows the accumulator converted back to half precision. The conversion uses a leading-one search and round-to-nearest-even. Operands arrive on a valid/ready handshake, and a clear input restarts the sum.

Top module: `fp16_slice_mac`

## Requirements
- R1: An operand pair whose exponent fields are both in 1..30 is accepted when in_valid and in_ready are both high at a clock edge. in_ready is then low for exactly 9 cycles. The sum and result change at the ninth edge after acceptance, and in_ready is high again after that edge.
- R2: An operand whose exponent field is 0 is treated as zero. This covers zero and subnormal inputs, and applies when neither operand has exponent field 31. Such a pair is accepted in a single cycle, in_ready stays high, and the result and flags do not change.
- R3: Let ea and eb be the biased exponents, and let ma and mb be 1024 plus the fraction fields. The product has significand P = ma·mb and exponent sum pe = ea+eb. The first product after a clear or reset sets the reference ref = pe. A product with d = pe−ref in −8..8 adds floor(P·2^(d+8)/2^14) to the signed accumulator, with the sign of a XOR b (bit 15 of each operand). The accumulator value is acc·2^(ref−44).
- R4: A product with d < −8 is discarded, and the truncated flag is set. That flag stays set until a clear.
- R5: A product with d > 8 sets the accumulator to ±(2^25−1), with the product's sign, and sets the overflow flag. A sum that falls outside ±(2^25−1) is clamped to that bound and also sets the overflow flag.
- R6: An operand with exponent field 31 counts as infinity, whatever its fraction. It sets the accumulator to ±(2^25−1), with sign a XOR b, and sets the overflow flag. While the overflow flag is set, the accumulator is frozen and the result is 0x7C00 or 0xFC00, following the accumulator sign. This lasts until a clear.
- R7: The result is in FP16 format: sign in bit 15, biased exponent in bits 14:10 with bias 15, and fraction in bits 9:0. Without overflow, the result is |acc| normalised by its leading one at position L, rounded to 11 significant bits with ties to even, with exponent E = L+ref−29 (adjusted for a rounding carry). E ≥ 31 gives a signed infinity. E ≤ 0, a zero sum, or an empty sum gives 0x0000.
- R8: A clear, when sampled, resets in that same cycle the accumulator, the reference, both flags and any product still being sliced, including one on its last slice. An operand pair accepted in the clear cycle becomes the first term of the new sum. Reset leaves in_ready high, the result at 0x0000 and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart the sum |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit can take an operand pair |
| op_a | input | 16 | First FP16 operand |
| op_b | input | 16 | Second FP16 operand |
| result | output | 16 | Running sum in FP16 |
| ovf_flag | output | 1 | Sum saturated or infinity seen |
| trunc_flag | output | 1 | A product fell below the window |

## Verification
A clear can be sampled on the same edge as the last slice of a product in progress. That product must then vanish instead of landing in the freshly cleared sum. The bench raises clear exactly on that edge, and on a mid-product edge for comparison. It judges both by the result returning to 0x0000, in_ready rising on the next cycle, and the next product being treated as a first term that sets the reference. A clear is also driven in the same cycle as an operand acceptance, and the result must then equal that operand pair's product alone.

// File: rtl/fp16_slice_mac.sv
module fp16_slice_mac #(
  parameter int SPAN  = 8,
  parameter int ACC_W = 26
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  output logic [15:0] result,
  output logic        ovf_flag,
  output logic        trunc_flag
);
  localparam int MW   = 11;
  localparam int PW   = 2 * MW;
  localparam int TW   = ACC_W - 2;
  localparam int DROP = PW + SPAN - TW;
  localparam int XW   = PW + 2 * SPAN;
  localparam int EW   = 6;
  localparam int MAGW = ACC_W - 1;
  localparam int LW   = $clog2(MAGW);
  localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]   SMAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [7:0]       HI_S = 8'(SPAN);

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [EW-1:0] ref_q, ref_d, pe_q, pe_d, ref_eff;
  logic has_q, has_d, ovf_q, ovf_d, trunc_q, trunc_d, busy_q, busy_d, neg_q, neg_d;
  logic [1:0] si_q, si_d, sj_q, sj_d;
  logic [MW-1:0] ma_q, ma_d, mb_q, mb_d;
  logic [PW-1:0] prod_q, prod_d, pp, prod_full;
  logic [7:0] pp8;

  function automatic logic [3:0] slice(input logic [MW-1:0] m, input logic [1:0] k);
    case (k)
      2'd0:    slice = m[3:0];
      2'd1:    slice = m[7:4];
      default: slice = {1'b0, m[10:8]};
    endcase
  endfunction

  wire [4:0] ea = op_a[14:10];
  wire [4:0] eb = op_b[14:10];
  wire a_inf = &ea, b_inf = &eb;
  wire a_zero = ~|ea, b_zero = ~|eb;
  wire any_inf = a_inf | b_inf;
  wire take = in_valid & ~busy_q;
  wire last = busy_q & (si_q == 2'd2) & (sj_q == 2'd2);

  assign in_ready   = ~busy_q;
  assign ovf_flag   = ovf_q;
  assign trunc_flag = trunc_q;

  assign pp8 = slice(ma_q, si_q) * slice(mb_q, sj_q);
  assign pp = PW'(pp8) << {({1'b0, si_q} + {1'b0, sj_q}), 2'b00};
  assign prod_full = prod_q + pp;

  assign ref_eff = has_q ? ref_q : pe_q;
  logic signed [7:0] d;
  logic [7:0] shv;
  logic [TW-1:0] term;
  logic [ACC_W:0] term_s;
  logic signed [ACC_W:0] sum;
  assign d = $signed({2'b00, pe_q}) - $signed({2'b00, ref_eff});
  assign shv = d + HI_S;
  assign term = TW'((XW'(prod_full) << shv) >> (SPAN + DROP));
  assign term_s = {{(ACC_W+1-TW){1'b0}}, term};
  assign sum = {acc_q[ACC_W-1], acc_q} + (neg_q ? -term_s : term_s);

  always_comb begin
    acc_d = acc_q; ref_d = ref_q; has_d = has_q; ovf_d = ovf_q; trunc_d = trunc_q;
    busy_d = busy_q; si_d = si_q; sj_d = sj_q; prod_d = prod_q;
    ma_d = ma_q; mb_d = mb_q; pe_d = pe_q; neg_d = neg_q;
    if (clear) begin
      acc_d = '0; ref_d = '0; has_d = 1'b0; ovf_d = 1'b0; trunc_d = 1'b0; busy_d = 1'b0;
    end else if (busy_q) begin
      prod_d = prod_full;
      if (sj_q == 2'd2) begin
        sj_d = 2'd0;
        si_d = si_q + 2'd1;
      end else begin
        sj_d = sj_q + 2'd1;
      end
      if (last) begin
        busy_d = 1'b0;
        if (!ovf_q) begin
          has_d = 1'b1;
          ref_d = ref_eff;
          if (d > HI_S) begin
            acc_d = neg_q ? -MAXV : MAXV;
            ovf_d = 1'b1;
          end else if (d < -HI_S) begin
            trunc_d = 1'b1;
          end else if (sum > SMAX) begin
            acc_d = MAXV;
            ovf_d = 1'b1;
          end else if (sum < -SMAX) begin
            acc_d = -MAXV;
            ovf_d = 1'b1;
          end else begin
            acc_d = sum[ACC_W-1:0];
          end
        end
      end
    end
    if (take) begin
      if (any_inf) begin
        if (!ovf_d) begin
          acc_d = (op_a[15] ^ op_b[15]) ? -MAXV : MAXV;
          ovf_d = 1'b1;
        end
      end else if (!a_zero && !b_zero) begin
        ma_d = {1'b1, op_a[9:0]};
        mb_d = {1'b1, op_b[9:0]};
        pe_d = {1'b0, ea} + {1'b0, eb};
        neg_d = op_a[15] ^ op_b[15];
        prod_d = '0; si_d = 2'd0; sj_d = 2'd0; busy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; ref_q <= '0; has_q <= 1'b0; ovf_q <= 1'b0; trunc_q <= 1'b0;
      busy_q <= 1'b0; si_q <= '0; sj_q <= '0; prod_q <= '0;
      ma_q <= '0; mb_q <= '0; pe_q <= '0; neg_q <= 1'b0;
    end else begin
      acc_q <= acc_d; ref_q <= ref_d; has_q <= has_d; ovf_q <= ovf_d; trunc_q <= trunc_d;
      busy_q <= busy_d; si_q <= si_d; sj_q <= sj_d; prod_q <= prod_d;
      ma_q <= ma_d; mb_q <= mb_d; pe_q <= pe_d; neg_q <= neg_d;
    end
  end

  logic sgn, carry, up;
  logic [MAGW-1:0] mag, norm;
  logic [LW-1:0] lead;
  logic [10:0] sig_r;
  int ex;
  always_comb begin
    sgn = acc_q[ACC_W-1];
    mag = sgn ? MAGW'(-acc_q) : MAGW'(acc_q);
    lead = '0;
    for (int k = 0; k < MAGW; k++) if (mag[k]) lead = LW'(k);
    norm = mag << (LW'(MAGW - 1) - lead);
    up = norm[MAGW-12] & ((|norm[MAGW-13:0]) | norm[MAGW-11]);
    sig_r = {1'b0, norm[MAGW-2 -: 10]} + {10'd0, up};
    carry = sig_r[10];
    ex = int'(lead) + int'(ref_q) + DROP - 35 + int'(carry);
    if (ovf_q)               result = {sgn, 5'h1F, 10'h000};
    else if (!norm[MAGW-1])  result = 16'h0000;
    else if (ex >= 31)       result = {sgn, 5'h1F, 10'h000};
    else if (ex <= 0)        result = 16'h0000;
    else                     result = {sgn, ex[4:0], sig_r[9:0]};
  end

  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !any_inf && !a_zero && !b_zero |=> !in_ready);
  p_zero_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && !any_inf && (a_zero || b_zero) && !clear |=> in_ready && $stable(result));
  p_trunc_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_flag && !clear |=> trunc_flag);
  p_ovf_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !clear |=> ovf_flag && $stable(result));
  p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !(take && any_inf) |=> !ovf_flag && !trunc_flag);
  p_clear_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !in_ready |=> in_ready);
endmodule

// File: tb/fp16_slice_mac_bench.sv
module fp16_slice_mac_bench;
  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic in_ready, ovf_flag, trunc_flag;
  logic [15:0] result;
  int checks = 0, errors = 0;

  localparam longint MAXM = (longint'(1) << 25) - 1;
  longint m_acc = 0;
  int m_ref = 0;
  bit m_has = 0, m_ovf = 0, m_trunc = 0;

  fp16_slice_mac u_fp16_slice_mac (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .result(result), .ovf_flag(ovf_flag), .trunc_flag(trunc_flag));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    m_acc = 0; m_ref = 0; m_has = 0; m_ovf = 0; m_trunc = 0;
  endtask

  task automatic m_prod(input logic [15:0] x, input logic [15:0] y);
    int ex, ey, pe, dd;
    bit s;
    longint p, t;
    ex = int'(x[14:10]); ey = int'(y[14:10]); s = x[15] ^ y[15];
    if (ex == 31 || ey == 31) begin
      if (!m_ovf) begin m_acc = s ? -MAXM : MAXM; m_ovf = 1; end
      return;
    end
    if (ex == 0 || ey == 0 || m_ovf) return;
    p = longint'(1024 + int'(x[9:0])) * longint'(1024 + int'(y[9:0]));
    pe = ex + ey;
    if (!m_has) begin m_has = 1; m_ref = pe; end
    dd = pe - m_ref;
    if (dd > 8) begin
      m_acc = s ? -MAXM : MAXM; m_ovf = 1;
    end else if (dd < -8) begin
      m_trunc = 1;
    end else begin
      t = (p << (dd + 8)) >> 14;
      m_acc = s ? m_acc - t : m_acc + t;
      if (m_acc > MAXM) begin m_acc = MAXM; m_ovf = 1; end
      if (m_acc < -MAXM) begin m_acc = -MAXM; m_ovf = 1; end
    end
  endtask

  function automatic logic [15:0] m_result();
    longint mag, q, rem, half;
    int lz, e, sh;
    bit s;
    s = m_acc < 0;
    if (m_ovf) return {s, 5'h1F, 10'h000};
    mag = s ? -m_acc : m_acc;
    if (mag == 0) return 16'h0000;
    lz = 0;
    for (int k = 0; k < 40; k++) if ((mag >> k) & 1) lz = k;
    if (lz > 10) begin
      sh = lz - 10;
      q = mag >> sh;
      rem = mag - (q << sh);
      half = longint'(1) << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == 2048) begin q = 1024; lz = lz + 1; end
    end else begin
      q = mag << (10 - lz);
    end
    e = lz + m_ref - 29;
    if (e >= 31) return {s, 5'h1F, 10'h000};
    if (e <= 0) return 16'h0000;
    return {s, 5'(e), q[9:0]};
  endfunction

  task automatic send(input logic [15:0] x, input logic [15:0] y, output int lowc);
    while (!in_ready) @(negedge clk);
    op_a = x; op_b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lowc = 0;
    while (!in_ready) begin lowc++; @(negedge clk); end
    m_prod(x, y);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    m_clear();
  endtask

  task automatic state(input string tag);
    chk({tag, " result"}, longint'(result), longint'(m_result()));
    chk({tag, " ovf"}, longint'(ovf_flag), longint'(m_ovf));
    chk({tag, " trunc"}, longint'(trunc_flag), longint'(m_trunc));
  endtask

  function automatic logic [15:0] fp(input bit s, input int e, input int f);
    return {s, 5'(e), 10'(f)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lc;
    logic [15:0] x, y;
    void'($urandom(32'd20251123));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset ready", longint'(in_ready), 1);
    state("R8 reset");

    send(16'h3C00, 16'h3C00, lc);
    chk("R1 nine slice cycles", lc, 9);
    chk("R3 one times one", longint'(result), 16'h3C00);
    send(16'h4000, 16'hBC00, lc);
    state("R3 signed sum");

    send(16'h0000, 16'h4500, lc);
    chk("R2 zero no cycles", lc, 0);
    state("R2 zero ignored");
    send(16'h0123, 16'h3C00, lc);
    chk("R2 subnormal no cycles", lc, 0);
    state("R2 subnormal ignored");
    do_clear();

    send(fp(0, 15, 1), fp(0, 15, 512), lc);
    chk("R7 tie odd rounds up", longint'(result), longint'(m_result()));
    chk("R7 tie odd value", longint'(result), 16'h3E02);
    do_clear();
    send(fp(0, 15, 2), fp(0, 15, 256), lc);
    chk("R7 tie even stays", longint'(result), 16'h3D02);
    do_clear();

    send(fp(0, 20, 0), fp(0, 20, 0), lc);
    send(fp(0, 15, 0), fp(0, 15, 0), lc);
    state("R4 below window");
    send(fp(0, 20, 0), fp(0, 20, 0), lc);
    chk("R4 trunc sticky", longint'(trunc_flag), 1);
    state("R4 after more");
    do_clear();
    state("R8 clear drops trunc");

    send(fp(0, 15, 0), fp(0, 15, 0), lc);
    send(fp(0, 20, 0), fp(0, 20, 0), lc);
    chk("R5 above window ovf", longint'(ovf_flag), 1);
    state("R5 above window");
    do_clear();
    send(fp(1, 15, 0), fp(0, 15, 0), lc);
    for (int k = 0; k < 9; k++) send(fp(1, 19, 0), fp(0, 19, 0), lc);
    chk("R5 sum saturation ovf", longint'(ovf_flag), 1);
    chk("R5 sum saturation result", longint'(result), 16'hFC00);
    do_clear();

    send(16'h3C00, 16'h3C00, lc);
    send(16'h7C00, 16'h3C00, lc);
    chk("R6 inf no cycles", lc, 0);
    chk("R6 inf result", longint'(result), 16'h7C00);
    send(16'hC000, 16'h4000, lc);
    state("R6 frozen");
    do_clear();
    send(16'hFC00, 16'h3C00, lc);
    chk("R6 negative inf", longint'(result), 16'hFC00);
    do_clear();

    send(fp(0, 30, 0), fp(0, 30, 0), lc);
    chk("R7 exponent too large", longint'(result), 16'h7C00);
    chk("R7 no ovf flag", longint'(ovf_flag), 0);
    do_clear();
    send(fp(0, 1, 0), fp(0, 1, 0), lc);
    chk("R7 exponent too small", longint'(result), 16'h0000);
    do_clear();

    send(16'h3C00, 16'h3C00, lc);
    op_a = 16'h4000; op_b = 16'h4000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_clear();
    chk("R8 mid-product ready", longint'(in_ready), 1);
    state("R8 mid-product clear");

    send(16'h3C00, 16'h3C00, lc);
    op_a = 16'h4400; op_b = 16'h4000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    do_clear();
    chk("R8 last-slice ready", longint'(in_ready), 1);
    state("R8 last-slice clear");
    repeat (12) @(negedge clk);
    chk("R8 cancelled product absent", longint'(result), 16'h0000);
    send(fp(0, 10, 0), fp(0, 10, 0), lc);
    state("R8 new reference");

    op_a = 16'h4000; op_b = 16'h3C00; in_valid = 1'b1; clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b0;
    m_clear();
    m_prod(16'h4000, 16'h3C00);
    while (!in_ready) @(negedge clk);
    chk("R8 accept with clear", longint'(result), 16'h4000);
    do_clear();

    for (int set = 0; set < 30; set++) begin
      int base, n;
      base = 8 + int'($urandom_range(0, 10));
      n = 1 + int'($urandom_range(0, 5));
      for (int t = 0; t < n; t++) begin
        x = fp(1'($urandom), base + int'($urandom_range(0, 4)), int'($urandom_range(0, 1023)));
        y = fp(1'($urandom), base + int'($urandom_range(0, 4)), int'($urandom_range(0, 1023)));
        if ($urandom_range(0, 9) == 0) x[14:10] = 5'd0;
        send(x, y, lc);
        chk("R1 R2 slice count", lc, (x[14:10] == 5'd0) ? 0 : 9);
      end
      state("R3 random set");
      do_clear();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule